// File: doc/BRIEF.md
# Straddling Completion Stream Packer

This block takes an ordinary packet stream, one 16-byte slot per input beat, and packs the packets back to back into a 32-Dword output beat. Each input beat carries up to four Dwords. A flag marks the first beat of a packet and another marks the last, and a per-Dword keep is used on the last beat. Every accepted input beat takes the next free 4-Dword slot of the beat being built. A packet that closes part way through a slot leaves the rest of that slot zero, and the next packet starts in the following slot. When a packet runs past slot 7, it continues in slot 0 of the next output beat.

For each output beat the block reports packet boundaries through two thermometer masks and two pointer vectors. One pair gives the starts: the slot index of each packet that begins. The other pair gives the ends: the Dword index of each packet's last Dword. The output keep is held at all ones and the output last at zero, so the downstream logic must use the masks to find packets. The beat being built is sent once its eighth slot is filled. It is also sent early, partly filled, as soon as the input has nothing to offer.

Both sides use a valid/ready handshake. The output holds its beat and all marker fields unchanged while valid is high and ready is low. The input side is stalled only when the beat being built is full and the output register is still occupied.

Top module: `strd_packer`

## Requirements
- R1: An input beat is taken on a rising clock edge where in_valid and in_ready are both high. in_sop marks the first beat of a packet and in_last marks the final beat. in_keep holds one bit per Dword, bit k for Dword k (bits [32k+31:32k]); it is contiguous from bit 0 and all ones on beats that are not last.
- R2: Each accepted beat is written into the next slot of the beat being built. Slot s covers Dwords 4s to 4s+3, which are bits [128s+127:128s] of out_data. A packet that crosses the end of slot 7 continues in slot 0 of the following output beat.
- R3: Every Dword of an emitted beat that no accepted input Dword filled reads as zero. This includes Dwords whose keep bit was low.
- R4: out_sop_mask is a thermometer code whose count of ones equals the number of packets starting in the beat. Entry i of out_sop_ptr, at bits [3i+2:3i], holds the slot index of the i-th start in order of position. Unused entries read zero.
- R5: out_eop_mask is a thermometer code whose count of ones equals the number of packets ending in the beat. Entry i of out_eop_ptr, at bits [5i+4:5i], holds the Dword index (0 to 31) of the last Dword of the i-th packet ending in the beat. A packet that started in an earlier beat reports its end in entry 0. Unused entries read zero.
- R6: While out_valid is high, out_keep is all ones and out_last is zero.
- R7: A beat whose eighth slot is filled is presented on the next cycle. If the output is free, input is accepted in that same cycle into slot 0 of the next beat, so a continuous input never stalls.
- R8: When the beat being built holds at least one slot, in_valid is low and the output is free, the partial beat is presented on the next cycle. Its masks count only the packets placed in it.
- R9: While out_valid is high and out_ready is low, out_valid, out_data and all marker outputs hold. in_ready is low only when the beat being built is full and the output is stalled.
- R10: After reset, out_valid is low, in_ready is high and the beat being built is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_data | input | 128 | Four Dwords, Dword k at bits [32k+31:32k] |
| in_keep | input | 4 | Per-Dword keep, contiguous from bit 0 |
| in_sop | input | 1 | First beat of a packet |
| in_last | input | 1 | Final beat of a packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 1024 | 32 Dwords, unused Dwords zero |
| out_keep | output | 32 | Held all ones |
| out_last | output | 1 | Held zero |
| out_sop_mask | output | 8 | Thermometer count of packet starts |
| out_sop_ptr | output | 24 | Eight 3-bit start slot indices |
| out_eop_mask | output | 8 | Thermometer count of packet ends |
| out_eop_ptr | output | 40 | Eight 5-bit last-Dword indices |

## Verification
The assertions check the ordering and thermometer shape of the markers, and they depend on well-formed packets at the input. Each packet must open with in_sop before in_last, keep must be contiguous, and keep must be full on every beat that is not last. Once raised, in_valid must stay up with stable fields until the beat is accepted. The directed stimulus builds each packet beat by beat from its length and holds every beat until in_ready is seen high. Only the keep lanes left past a packet's last Dword carry junk data, so that the zero-fill rule is tested while the input contract is still respected.

// File: rtl/strd_pkg.sv
package strd_pkg;
  // Width of one Dword and the number of Dwords in one 16-byte slot.
  localparam int DWORD_BITS  = 32;
  localparam int SLOT_DWORDS = 4;
  // Number of slots that make up one output beat.
  localparam int BEAT_SLOTS  = 8;
endpackage

// File: rtl/strd_slot_fill.sv
// Holds the data of the beat under construction, one register per slot.
module strd_slot_fill #(
  parameter int NSLOT   = 8,
  parameter int SLOT_DW = 4,
  parameter int DWORD_W = 32,
  parameter int SLOT_W  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic                             wr_en,
  input  logic [SLOT_W-1:0]                wr_slot,
  input  logic [SLOT_DW*DWORD_W-1:0]       wr_data,
  input  logic [SLOT_DW-1:0]               wr_keep,
  output logic [NSLOT*SLOT_DW*DWORD_W-1:0] beat
);
  localparam int SW_BITS = SLOT_DW * DWORD_W;

  logic [SW_BITS-1:0] masked;

  for (genvar k = 0; k < SLOT_DW; k++) begin : g_mask
    assign masked[k*DWORD_W +: DWORD_W] = wr_keep[k] ? wr_data[k*DWORD_W +: DWORD_W] : '0;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic               hit;
    logic [SW_BITS-1:0] q;
    assign hit = wr_en && (wr_slot == SLOT_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (hit)   q <= masked;
      else if (clear) q <= '0;
    end
    assign beat[s*SW_BITS +: SW_BITS] = q;
  end
endmodule

// File: rtl/strd_mark_track.sv
// Counts starts and ends in the beat under construction and records their pointers.
module strd_mark_track #(
  parameter int NSLOT  = 8,
  parameter int SLOT_W = 3,
  parameter int SUB_W  = 2,
  parameter int CNT_W  = 4,
  parameter int DPTR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     wr_en,
  input  logic [SLOT_W-1:0]        wr_slot,
  input  logic                     is_start,
  input  logic                     is_end,
  input  logic [SUB_W-1:0]         end_sub,
  output logic [CNT_W-1:0]         sop_cnt,
  output logic [CNT_W-1:0]         eop_cnt,
  output logic [NSLOT*SLOT_W-1:0]  sop_ptr,
  output logic [NSLOT*DPTR_W-1:0]  eop_ptr
);
  logic [CNT_W-1:0] sop_base, eop_base;
  logic             add_sop, add_eop;

  assign sop_base = clear ? '0 : sop_cnt;
  assign eop_base = clear ? '0 : eop_cnt;
  assign add_sop  = wr_en && is_start;
  assign add_eop  = wr_en && is_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sop_cnt <= '0;
      eop_cnt <= '0;
    end else if (clear || wr_en) begin
      sop_cnt <= sop_base + CNT_W'(add_sop);
      eop_cnt <= eop_base + CNT_W'(add_eop);
    end
  end

  for (genvar e = 0; e < NSLOT; e++) begin : g_entry
    logic [SLOT_W-1:0] sq;
    logic [DPTR_W-1:0] eq;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sq <= '0;
        eq <= '0;
      end else begin
        if (add_sop && sop_base == CNT_W'(e)) sq <= wr_slot;
        else if (clear)                       sq <= '0;
        if (add_eop && eop_base == CNT_W'(e)) eq <= {wr_slot, end_sub};
        else if (clear)                       eq <= '0;
      end
    end
    assign sop_ptr[e*SLOT_W +: SLOT_W] = sq;
    assign eop_ptr[e*DPTR_W +: DPTR_W] = eq;
  end
endmodule

// File: rtl/strd_out_hold.sv
// Output holding register: captures a finished beat and keeps it until taken.
module strd_out_hold #(
  parameter int BEAT_W = 1024,
  parameter int NSLOT  = 8,
  parameter int SLOT_W = 3,
  parameter int DPTR_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [BEAT_W-1:0]       d_data,
  input  logic [NSLOT-1:0]        d_sop_mask,
  input  logic [NSLOT*SLOT_W-1:0] d_sop_ptr,
  input  logic [NSLOT-1:0]        d_eop_mask,
  input  logic [NSLOT*DPTR_W-1:0] d_eop_ptr,
  input  logic                    q_ready,
  output logic                    q_valid,
  output logic [BEAT_W-1:0]       q_data,
  output logic [NSLOT-1:0]        q_sop_mask,
  output logic [NSLOT*SLOT_W-1:0] q_sop_ptr,
  output logic [NSLOT-1:0]        q_eop_mask,
  output logic [NSLOT*DPTR_W-1:0] q_eop_ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_valid <= 1'b0;
    else if (load)    q_valid <= 1'b1;
    else if (q_ready) q_valid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data     <= '0;
      q_sop_mask <= '0;
      q_sop_ptr  <= '0;
      q_eop_mask <= '0;
      q_eop_ptr  <= '0;
    end else if (load) begin
      q_data     <= d_data;
      q_sop_mask <= d_sop_mask;
      q_sop_ptr  <= d_sop_ptr;
      q_eop_mask <= d_eop_mask;
      q_eop_ptr  <= d_eop_ptr;
    end
  end
endmodule

// File: rtl/strd_packer.sv
// Packs slot-wide packet beats back to back into wide beats with start/end markers.
module strd_packer
  import strd_pkg::*;
#(
  parameter  int NSLOT   = BEAT_SLOTS,
  parameter  int SLOT_DW = SLOT_DWORDS,
  parameter  int DWORD_W = DWORD_BITS,
  localparam int SLOT_W  = $clog2(NSLOT),
  localparam int SUB_W   = $clog2(SLOT_DW),
  localparam int DPTR_W  = SLOT_W + SUB_W,
  localparam int IN_W    = SLOT_DW * DWORD_W,
  localparam int BEAT_DW = NSLOT * SLOT_DW,
  localparam int BEAT_W  = BEAT_DW * DWORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [IN_W-1:0]         in_data,
  input  logic [SLOT_DW-1:0]      in_keep,
  input  logic                    in_sop,
  input  logic                    in_last,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [BEAT_W-1:0]       out_data,
  output logic [BEAT_DW-1:0]      out_keep,
  output logic                    out_last,
  output logic [NSLOT-1:0]        out_sop_mask,
  output logic [NSLOT*SLOT_W-1:0] out_sop_ptr,
  output logic [NSLOT-1:0]        out_eop_mask,
  output logic [NSLOT*DPTR_W-1:0] out_eop_ptr
);
  localparam int CNT_W = $clog2(NSLOT + 1);
  localparam int KN_W  = $clog2(SLOT_DW + 1);

  logic [CNT_W-1:0]        fill;
  logic                    full, out_free, flush, acc;
  logic [SLOT_W-1:0]       wr_slot;
  logic [KN_W-1:0]         keep_n;
  logic [SUB_W-1:0]        end_sub;
  logic [BEAT_W-1:0]       b_data;
  logic [CNT_W-1:0]        sop_cnt, eop_cnt;
  logic [NSLOT*SLOT_W-1:0] b_sop_ptr;
  logic [NSLOT*DPTR_W-1:0] b_eop_ptr;
  logic [NSLOT-1:0]        b_sop_mask, b_eop_mask;

  // Flow control: send when full, or early when the input is dry.
  assign full     = (fill == CNT_W'(NSLOT));
  assign out_free = !out_valid || out_ready;
  assign flush    = (fill != '0) && (full || !in_valid) && out_free;
  assign in_ready = !full || flush;
  assign acc      = in_valid && in_ready;
  assign wr_slot  = flush ? '0 : fill[SLOT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fill <= '0;
    else if (flush) fill <= acc ? CNT_W'(1) : '0;
    else if (acc)   fill <= fill + CNT_W'(1);
  end

  // Index of the last kept Dword inside the slot.
  always_comb begin
    keep_n = '0;
    for (int k = 0; k < SLOT_DW; k++) keep_n = keep_n + KN_W'(in_keep[k]);
  end
  assign end_sub = SUB_W'(keep_n - KN_W'(1));

  strd_slot_fill #(
    .NSLOT(NSLOT), .SLOT_DW(SLOT_DW), .DWORD_W(DWORD_W), .SLOT_W(SLOT_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .clear(flush), .wr_en(acc), .wr_slot(wr_slot),
    .wr_data(in_data), .wr_keep(in_keep), .beat(b_data)
  );

  strd_mark_track #(
    .NSLOT(NSLOT), .SLOT_W(SLOT_W), .SUB_W(SUB_W), .CNT_W(CNT_W), .DPTR_W(DPTR_W)
  ) u_mark (
    .clk(clk), .rst_n(rst_n), .clear(flush), .wr_en(acc), .wr_slot(wr_slot),
    .is_start(in_sop), .is_end(in_last), .end_sub(end_sub),
    .sop_cnt(sop_cnt), .eop_cnt(eop_cnt), .sop_ptr(b_sop_ptr), .eop_ptr(b_eop_ptr)
  );

  // Counts become thermometer masks.
  for (genvar i = 0; i < NSLOT; i++) begin : g_therm
    assign b_sop_mask[i] = (sop_cnt > CNT_W'(i));
    assign b_eop_mask[i] = (eop_cnt > CNT_W'(i));
  end

  strd_out_hold #(
    .BEAT_W(BEAT_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W), .DPTR_W(DPTR_W)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .load(flush),
    .d_data(b_data), .d_sop_mask(b_sop_mask), .d_sop_ptr(b_sop_ptr),
    .d_eop_mask(b_eop_mask), .d_eop_ptr(b_eop_ptr),
    .q_ready(out_ready), .q_valid(out_valid), .q_data(out_data),
    .q_sop_mask(out_sop_mask), .q_sop_ptr(out_sop_ptr),
    .q_eop_mask(out_eop_mask), .q_eop_ptr(out_eop_ptr)
  );

  assign out_keep = '1;
  assign out_last = 1'b0;
endmodule

// File: rtl/strd_packer_chk.sv
module strd_packer_chk #(
  parameter int NSLOT   = 8,
  parameter int SLOT_W  = 3,
  parameter int DPTR_W  = 5,
  parameter int BEAT_DW = 32,
  parameter int BEAT_W  = 1024
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [BEAT_W-1:0]       out_data,
  input logic [BEAT_DW-1:0]      out_keep,
  input logic                    out_last,
  input logic [NSLOT-1:0]        out_sop_mask,
  input logic [NSLOT*SLOT_W-1:0] out_sop_ptr,
  input logic [NSLOT-1:0]        out_eop_mask,
  input logic [NSLOT*DPTR_W-1:0] out_eop_ptr
);
  p_keep_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((&out_keep) && !out_last));

  p_sop_thermo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_sop_mask & (out_sop_mask + 1'b1)) == '0));

  p_eop_thermo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_eop_mask & (out_eop_mask + 1'b1)) == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_sop_mask) && $stable(out_sop_ptr) &&
      $stable(out_eop_mask) && $stable(out_eop_ptr)));

  p_stall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  for (genvar i = 1; i < NSLOT; i++) begin : g_order
    p_sop_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sop_mask[i]) |->
        (out_sop_ptr[i*SLOT_W +: SLOT_W] > out_sop_ptr[(i-1)*SLOT_W +: SLOT_W]));
    p_eop_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_eop_mask[i]) |->
        (out_eop_ptr[i*DPTR_W +: DPTR_W] > out_eop_ptr[(i-1)*DPTR_W +: DPTR_W]));
  end
endmodule

bind strd_packer strd_packer_chk #(
  .NSLOT(NSLOT), .SLOT_W(SLOT_W), .DPTR_W(DPTR_W), .BEAT_DW(BEAT_DW), .BEAT_W(BEAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_keep(out_keep), .out_last(out_last),
  .out_sop_mask(out_sop_mask), .out_sop_ptr(out_sop_ptr),
  .out_eop_mask(out_eop_mask), .out_eop_ptr(out_eop_ptr)
);

// File: tb/strd_packer_bench.sv
`timescale 1ns/1ps
module strd_packer_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [127:0]  in_data = '0;
  logic [3:0]    in_keep = '0;
  logic          in_sop = 1'b0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1023:0] out_data;
  logic [31:0]   out_keep;
  logic          out_last;
  logic [7:0]    out_sop_mask;
  logic [23:0]   out_sop_ptr;
  logic [7:0]    out_eop_mask;
  logic [39:0]   out_eop_ptr;

  int checks = 0;
  int fails = 0;
  int stalls = 0;
  bit done = 0;

  logic [1023:0] cap_d  [0:7];
  logic [7:0]    cap_sm [0:7];
  logic [23:0]   cap_sp [0:7];
  logic [7:0]    cap_em [0:7];
  logic [39:0]   cap_ep [0:7];
  logic          cap_kl [0:7];
  int            ncap = 0;
  logic [1023:0] exp_d;

  always #2.5 clk = ~clk;

  strd_packer u_strd_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_keep(in_keep), .in_sop(in_sop), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_keep(out_keep), .out_last(out_last), .out_sop_mask(out_sop_mask),
    .out_sop_ptr(out_sop_ptr), .out_eop_mask(out_eop_mask), .out_eop_ptr(out_eop_ptr)
  );

  // Monitor: samples 1 ns after the falling edge, well before the next rising edge.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready && ncap < 8) begin
      cap_d[ncap]  = out_data;
      cap_sm[ncap] = out_sop_mask;
      cap_sp[ncap] = out_sop_ptr;
      cap_em[ncap] = out_eop_mask;
      cap_ep[ncap] = out_eop_ptr;
      cap_kl[ncap] = (&out_keep) && !out_last;
      ncap++;
    end
  end

  function automatic logic [31:0] word(input int id, input int idx);
    return {id[15:0], idx[15:0]};
  endfunction

  function automatic logic [23:0] sptr(input logic [31:0] nib, input int n);
    logic [23:0] r = '0;
    for (int i = 0; i < n; i++) r[3*i +: 3] = nib[4*i +: 3];
    return r;
  endfunction

  function automatic logic [39:0] eptr(input logic [63:0] byt, input int n);
    logic [39:0] r = '0;
    for (int i = 0; i < n; i++) r[5*i +: 5] = byt[8*i +: 5];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [1023:0] act, input logic [1023:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input int pos, input int id, input int first, input int n);
    for (int k = 0; k < n; k++) exp_d[32*(pos+k) +: 32] = word(id, first + k);
  endtask

  task automatic chk_beat(input string req, input int b, input logic [7:0] sm,
                          input logic [23:0] sp, input logic [7:0] em, input logic [39:0] ep);
    chk(cap_d[b] == exp_d, req, "beat data", cap_d[b], exp_d);
    chk(cap_sm[b] == sm, req, "sop mask", 1024'(cap_sm[b]), 1024'(sm));
    chk(cap_sp[b] == sp, req, "sop ptr", 1024'(cap_sp[b]), 1024'(sp));
    chk(cap_em[b] == em, req, "eop mask", 1024'(cap_em[b]), 1024'(em));
    chk(cap_ep[b] == ep, req, "eop ptr", 1024'(cap_ep[b]), 1024'(ep));
    chk(cap_kl[b], "R6", "keep/last", 1024'(cap_kl[b]), 1024'(1));
  endtask

  // Drive one input beat at a falling edge and hold it until accepted.
  task automatic send_beat(input int id, input int first, input int n,
                           input bit sop, input bit last);
    bit ok = 0;
    in_valid = 1'b1;
    in_sop   = sop;
    in_last  = last;
    in_keep  = 4'((1 << n) - 1);
    for (int k = 0; k < 4; k++)
      in_data[32*k +: 32] = (k < n) ? word(id, first + k) : 32'hDEAD_BEEF;
    while (!ok) begin
      #1;
      ok = in_ready;
      if (!ok) stalls++;
      @(negedge clk);
    end
  endtask

  task automatic send_pkt(input int id, input int ndw);
    int nb = (ndw + 3) / 4;
    for (int b = 0; b < nb; b++) begin
      int rem = ndw - 4 * b;
      send_beat(id, 4 * b, (rem > 4) ? 4 : rem, b == 0, b == nb - 1);
    end
  endtask

  task automatic go_idle(input int cyc);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_last  = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R10", "out_valid after reset", 1024'(out_valid), 1024'(0));
    chk(in_ready == 1'b1, "R10", "in_ready after reset", 1024'(in_ready), 1024'(1));
  endtask

  // Single short packet, partial beat flushed on dry input.
  task automatic t_single;
    ncap = 0;
    exp_d = '0;
    send_pkt(1, 3);
    go_idle(10);
    chk(ncap == 1, "R8", "beat count", 1024'(ncap), 1024'(1));
    put(0, 1, 0, 3);
    chk_beat("R3", 0, 8'h01, sptr(32'h0, 1), 8'h01, eptr(64'h02, 1));
  endtask

  // Mixed lengths straddling a beat boundary.
  task automatic t_straddle;
    ncap = 0;
    send_pkt(2, 5);
    send_pkt(3, 4);
    send_pkt(4, 9);
    send_pkt(5, 14);
    send_pkt(6, 1);
    go_idle(10);
    chk(ncap == 2, "R2", "beat count", 1024'(ncap), 1024'(2));
    exp_d = '0;
    put(0, 2, 0, 5);
    put(8, 3, 0, 4);
    put(12, 4, 0, 9);
    put(24, 5, 0, 8);
    chk_beat("R2", 0, 8'h0F, sptr(32'h6320, 4), 8'h07, eptr(64'h140B04, 3));
    exp_d = '0;
    put(0, 5, 8, 6);
    put(8, 6, 0, 1);
    chk_beat("R5", 1, 8'h01, sptr(32'h2, 1), 8'h03, eptr(64'h0805, 2));
  endtask

  // Eight one-Dword packets fill a beat; a ninth follows without a stall.
  task automatic t_eight;
    ncap = 0;
    stalls = 0;
    for (int p = 0; p < 9; p++) send_pkt(10 + p, 1);
    chk(stalls == 0, "R7", "input stalls", 1024'(stalls), 1024'(0));
    go_idle(10);
    chk(ncap == 2, "R7", "beat count", 1024'(ncap), 1024'(2));
    exp_d = '0;
    for (int p = 0; p < 8; p++) put(4 * p, 10 + p, 0, 1);
    chk_beat("R4", 0, 8'hFF, sptr(32'h76543210, 8), 8'hFF, eptr(64'h1C1814100C080400, 8));
    exp_d = '0;
    put(0, 18, 0, 1);
    chk_beat("R8", 1, 8'h01, sptr(32'h0, 1), 8'h01, eptr(64'h0, 1));
  endtask

  // Output stalled: input must back off, then everything drains intact.
  task automatic t_backpressure;
    ncap = 0;
    out_ready = 1'b0;
    fork
      begin
        for (int p = 0; p < 17; p++) send_pkt(20 + p, 4);
        go_idle(1);
      end
      begin
        repeat (40) @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R9", "in_ready while stalled", 1024'(in_ready), 1024'(0));
        chk(out_valid == 1'b1, "R9", "out_valid while stalled", 1024'(out_valid), 1024'(1));
        chk(ncap == 0, "R9", "beats taken while stalled", 1024'(ncap), 1024'(0));
        @(negedge clk);
        out_ready = 1'b1;
      end
    join
    go_idle(10);
    chk(ncap == 3, "R9", "beat count", 1024'(ncap), 1024'(3));
    for (int b = 0; b < 2; b++) begin
      exp_d = '0;
      for (int p = 0; p < 8; p++) put(4 * p, 20 + 8 * b + p, 0, 4);
      chk_beat("R9", b, 8'hFF, sptr(32'h76543210, 8), 8'hFF, eptr(64'h1F1B17130F0B0703, 8));
    end
    exp_d = '0;
    put(0, 36, 0, 4);
    chk_beat("R1", 2, 8'h01, sptr(32'h0, 1), 8'h01, eptr(64'h03, 1));
  endtask

  // Input pauses inside a packet: open packet flushed, end reported in entry 0 later.
  task automatic t_gap;
    ncap = 0;
    send_beat(40, 0, 4, 1'b1, 1'b0);
    go_idle(3);
    send_beat(40, 4, 2, 1'b0, 1'b1);
    go_idle(10);
    chk(ncap == 2, "R8", "beat count", 1024'(ncap), 1024'(2));
    exp_d = '0;
    put(0, 40, 0, 4);
    chk_beat("R8", 0, 8'h01, sptr(32'h0, 1), 8'h00, eptr(64'h0, 0));
    exp_d = '0;
    put(0, 40, 4, 2);
    chk_beat("R5", 1, 8'h00, sptr(32'h0, 0), 8'h01, eptr(64'h01, 1));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_straddle;
    t_eight;
    t_backpressure;
    t_gap;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end
endmodule